// File: doc/BRIEF.md
# Base Address Window Decoder

This block holds the base address registers of one configurable function and claims incoming I/O or memory transactions that fall inside the windows those registers describe. Each register slot is fixed at elaboration time as unused, an I/O window, a 32-bit memory window, or the lower half of a 64-bit memory window. A 64-bit window takes the next slot as its upper half. Window sizes come from per-slot byte requests that are rounded up to powers of two.

Software programs the windows and the space-enable bits of the command word through a small configuration write/read port. Writes are masked to the window size, and reads return the fixed type bits. A transaction presents an address, a byte length and a space flag. In the same cycle the block reports whether a window claims it, which slot that window is in, and the byte offset of the transaction into the window.

Top module: `bar_window_decoder`

## Requirements
- R1: Every window size is the smallest power of two that is at least the request and at least the minimum for its type: 4 bytes for I/O and 16 bytes for memory. With the defaults, slot 0 is I/O with 32 bytes, slot 1 is 32-bit memory with 4 KiB, slots 2 and 3 form a 64-bit memory window of 8 GiB, slot 4 is unused, and slot 5 is 32-bit memory with 128 bytes.
- R2: A write to a slot stores the written dword ANDed with the inverse of (size - 1), so an all-ones write reads back as the negated size plus the type bits.
- R3: Reads of slot registers return the stored base ORed with type bits. For I/O the value is 0x1. For 32-bit memory it is 0x0. For the lower half of a 64-bit window it is 0xC: type 2 in bits 2:1 and prefetchable in bit 3.
- R4: The upper half of a 64-bit pair stores the written value ANDed with the inverse of ((lower size - 1) >> 32). With the default 8 GiB window, bit 0 of the upper half always reads 0.
- R5: A slot write whose length is not 4 bytes, or whose offset is not a multiple of 4, leaves every slot unchanged. An unused slot reads 0 and ignores writes.
- R6: The command word sits at configuration offset 0x04. Bit 0 enables I/O decode and bit 1 enables memory decode. Both bits are 0 after reset. A 1-, 2- or 4-byte write at offset 0x04 loads them from write-data bits 1:0. They read back at offset 0x04 in bits 1:0. Decoding follows the new value from the cycle after the write edge.
- R7: I/O windows claim only I/O transactions while command bit 0 is set. Memory windows claim only memory transactions while command bit 1 is set.
- R8: A window claims a transaction when address >= base and address + length <= base + size. The reported offset is address - base.
- R9: When several windows claim a transaction, the one in the lowest-numbered slot is reported.
- R10: Without a valid transaction, or when no window claims it, hit is 0 and slot and offset read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_bytes | input | 3 | Write length in bytes (1, 2 or 4) |
| cfg_wdata | input | 32 | Write data, right-justified |
| cfg_rdata | output | 32 | Read data of the dword holding cfg_addr |
| txn_valid | input | 1 | Transaction present |
| txn_io | input | 1 | 1 for I/O space, 0 for memory space |
| txn_addr | input | 64 | Transaction start address |
| txn_len | input | 4 | Transaction length in bytes |
| hit | output | 1 | A window claims the transaction |
| hit_bar | output | 3 | Slot number of the claiming window |
| hit_offset | output | 64 | Offset of the transaction into the window |

## Verification
A configuration write and a decode can fall in the same cycle. The two cases that matter are a command write that turns decoding on or off while a transaction is presented, and a base rewrite under a live transaction. The bench provokes both on purpose: it holds a memory transaction steady across a command write edge and expects no claim before the edge and a claim after it. In the random phase it mixes configuration writes with transactions, and a reference model updated only on clock edges judges every transaction.

// File: rtl/bar_window_decoder.sv
module bar_window_decoder #(
  parameter int NUM_BARS = 6,
  parameter logic [2*NUM_BARS-1:0] BAR_KIND = {2'd2, 2'd0, 2'd0, 2'd3, 2'd2, 2'd1},
  parameter logic [64*NUM_BARS-1:0] BAR_REQ = {64'd100, 64'd0, 64'd0, 64'h2_0000_0000, 64'd4096, 64'd20},
  localparam int IDX_W = $clog2(NUM_BARS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_addr,
  input  logic [2:0]        cfg_bytes,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              txn_valid,
  input  logic              txn_io,
  input  logic [63:0]       txn_addr,
  input  logic [3:0]        txn_len,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_bar,
  output logic [63:0]       hit_offset
);
  localparam logic [1:0] K_NONE = 2'd0;
  localparam logic [1:0] K_IO   = 2'd1;
  localparam logic [1:0] K_M32  = 2'd2;
  localparam logic [1:0] K_M64  = 2'd3;
  localparam logic [7:0] FIRST  = 8'h10;
  localparam logic [7:0] LAST   = 8'(16 + 4 * NUM_BARS);

  function automatic logic [1:0] kind_of(int j);
    if (j < 0 || j >= NUM_BARS) return K_NONE;
    return BAR_KIND[2*j +: 2];
  endfunction

  function automatic logic [63:0] size_of(int j);
    logic [63:0] p;
    if (kind_of(j) == K_NONE) return 64'd0;
    p = (kind_of(j) == K_IO) ? 64'd4 : 64'd16;
    for (int k = 0; k < 64; k++)
      if (p < BAR_REQ[64*j +: 64]) p = p << 1;
    return p;
  endfunction

  function automatic bit upper_of(int j);
    return (j > 0) && (kind_of(j - 1) == K_M64);
  endfunction

  logic [1:0]  cmd_q;
  logic [31:0] bar_q  [NUM_BARS];
  logic [31:0] rd_val [NUM_BARS];
  logic [63:0] sz_vec [NUM_BARS];
  logic [63:0] off    [NUM_BARS];
  logic [NUM_BARS-1:0] match;
  logic [32*NUM_BARS-1:0] bar_flat;
  logic [63:0] win_size;

  wire        bar_wr = cfg_wr && cfg_bytes == 3'd4 && cfg_addr[1:0] == 2'b00 &&
                       cfg_addr >= FIRST && cfg_addr < LAST;
  wire [7:0]  wr_idx = (cfg_addr - FIRST) >> 2;
  wire [64:0] txn_end = {1'b0, txn_addr} + 65'(txn_len);
  wire        cmd_wr = cfg_wr && cfg_addr == 8'h04 &&
                       (cfg_bytes == 3'd1 || cfg_bytes == 3'd2 || cfg_bytes == 3'd4);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cmd_q <= 2'b00;
    else if (cmd_wr) cmd_q <= cfg_wdata[1:0];

  for (genvar j = 0; j < NUM_BARS; j++) begin : g_bar
    localparam logic [1:0]  K    = kind_of(j);
    localparam logic [63:0] SZ   = size_of(j);
    localparam bit          HI   = upper_of(j);
    localparam logic [63:0] LOSZ = size_of(j - 1);
    localparam logic [31:0] MASK = HI ? ~32'((LOSZ - 64'd1) >> 32) : ~32'(SZ - 64'd1);
    localparam logic [31:0] TYPEBITS = (K == K_IO) ? 32'h1 : (K == K_M64) ? 32'hC : 32'h0;

    if (K == K_NONE && !HI) begin : g_empty
      assign bar_q[j] = 32'h0;
    end else begin : g_reg
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                           bar_q[j] <= 32'h0;
        else if (bar_wr && wr_idx == 8'(j))   bar_q[j] <= cfg_wdata & MASK;
    end

    assign rd_val[j] = bar_q[j] | TYPEBITS;
    assign bar_flat[32*j +: 32] = bar_q[j];
    assign sz_vec[j] = SZ;

    logic [63:0] base;
    logic        en;
    if (K == K_M64 && j + 1 < NUM_BARS) begin : g_b64
      assign base = {bar_q[j+1], bar_q[j]};
    end else begin : g_b32
      assign base = {32'h0, bar_q[j]};
    end
    if (K == K_IO) begin : g_en_io
      assign en = cmd_q[0] && txn_io;
    end else if (K == K_M32 || K == K_M64) begin : g_en_mem
      assign en = cmd_q[1] && !txn_io;
    end else begin : g_en_off
      assign en = 1'b0;
    end

    wire [64:0] lim = {1'b0, base} + {1'b0, SZ};
    assign match[j] = txn_valid && en && txn_addr >= base && txn_end <= lim;
    assign off[j]   = txn_addr - base;
  end

  always_comb begin
    hit = 1'b0;
    hit_bar = '0;
    hit_offset = 64'h0;
    win_size = 64'h0;
    for (int j = NUM_BARS - 1; j >= 0; j--)
      if (match[j]) begin
        hit = 1'b1;
        hit_bar = IDX_W'(j);
        hit_offset = off[j];
        win_size = sz_vec[j];
      end
  end

  always_comb begin
    cfg_rdata = 32'h0;
    if (cfg_addr[7:2] == 6'd1) cfg_rdata = {30'h0, cmd_q};
    for (int j = 0; j < NUM_BARS; j++)
      if (cfg_addr[7:2] == 6'(4 + j)) cfg_rdata = rd_val[j];
  end

  // R10
  idle_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_valid |-> !hit);
  // R7
  io_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && txn_io |-> cmd_q[0]);
  // R7
  mem_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !txn_io |-> cmd_q[1]);
  // R8
  offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> hit_offset + 64'(txn_len) <= win_size);
  // R5
  partial_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && (cfg_bytes != 3'd4 || cfg_addr[1:0] != 2'b00) |=> $stable(bar_flat));
  // R6
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && cfg_addr == 8'h04) |=> $stable(cmd_q));
endmodule

// File: tb/test_bar_window_decoder.sv
module test_bar_window_decoder;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_wr = 0;
  logic [7:0]  cfg_addr = 0;
  logic [2:0]  cfg_bytes = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic        txn_valid = 0;
  logic        txn_io = 0;
  logic [63:0] txn_addr = 0;
  logic [3:0]  txn_len = 0;
  logic        hit;
  logic [2:0]  hit_bar;
  logic [63:0] hit_offset;

  bar_window_decoder i_bar_window_decoder (.*);

  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] m [6];
  logic [1:0]  mcmd = 0;

  function automatic logic [63:0] bsize(int j);
    case (j)
      0: return 64'd32;
      1: return 64'd4096;
      2: return 64'h2_0000_0000;
      5: return 64'd128;
      default: return 64'd0;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] a);
    case (a[7:2])
      6'd1: return {30'h0, mcmd};
      6'd4: return m[0] | 32'h1;
      6'd5: return m[1];
      6'd6: return m[2] | 32'hC;
      6'd7: return m[3];
      6'd9: return m[5];
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_write(logic [7:0] a, logic [2:0] b, logic [31:0] d);
    if (a == 8'h04 && (b == 1 || b == 2 || b == 4)) mcmd = d[1:0];
    if (b == 4 && a[1:0] == 0 && a >= 8'h10 && a < 8'h28)
      case ((a - 8'h10) >> 2)
        0: m[0] = d & ~32'd31;
        1: m[1] = d & ~32'd4095;
        2: m[2] = 32'h0;
        3: m[3] = d & ~32'd1;
        5: m[5] = d & ~32'd127;
        default: ;
      endcase
  endtask

  task automatic exp_decode(logic v, logic io, logic [63:0] a, logic [3:0] l,
                            output logic eh, output logic [2:0] eb, output logic [63:0] eo);
    eh = 0; eb = 0; eo = 0;
    for (int j = 5; j >= 0; j--) begin
      logic [63:0] base;
      logic en;
      base = (j == 2) ? {m[3], m[2]} : {32'h0, m[j]};
      en = (j == 0) ? (mcmd[0] && io) : (j == 1 || j == 2 || j == 5) ? (mcmd[1] && !io) : 1'b0;
      if (v && en && {1'b0, a} >= {1'b0, base} &&
          {1'b0, a} + 65'(l) <= {1'b0, base} + {1'b0, bsize(j)}) begin
        eh = 1; eb = 3'(j); eo = a - base;
      end
    end
  endtask

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [2:0] b, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = a; cfg_bytes = b; cfg_wdata = d;
    @(posedge clk);
    model_write(a, b, d);
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, string req);
    @(negedge clk);
    cfg_addr = a;
    #2;
    check(cfg_rdata == exp_read(a), req, 64'(cfg_rdata), 64'(exp_read(a)));
  endtask

  task automatic rdv(logic [7:0] a, logic [31:0] v, string req);
    @(negedge clk);
    cfg_addr = a;
    #2;
    check(cfg_rdata == v && exp_read(a) == v, req, 64'(cfg_rdata), 64'(v));
  endtask

  task automatic tx(logic io, logic [63:0] a, logic [3:0] l, string req);
    logic eh; logic [2:0] eb; logic [63:0] eo;
    @(negedge clk);
    txn_valid = 1; txn_io = io; txn_addr = a; txn_len = l;
    #2;
    exp_decode(1'b1, io, a, l, eh, eb, eo);
    check(hit == eh && hit_bar == eb && hit_offset == eo, req,
          {hit, 3'b0, hit_bar, hit_offset[55:0]}, {eh, 3'b0, eb, eo[55:0]});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int j = 0; j < 6; j++) m[j] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    rdv(8'h04, 32'h0, "R6");
    rdv(8'h10, 32'h1, "R3");
    rdv(8'h18, 32'hC, "R3");
    rdv(8'h14, 32'h0, "R3");
    @(negedge clk); txn_valid = 0; txn_io = 0; txn_addr = 0; txn_len = 4;
    #2 check(!hit && hit_bar == 0 && hit_offset == 0, "R10", {63'h0, hit}, 64'h0);
    tx(1'b0, 64'h0, 4'd4, "R7");

    wr(8'h10, 3'd4, 32'hFFFF_FFFF); rdv(8'h10, 32'hFFFF_FFE1, "R1");
    wr(8'h14, 3'd4, 32'hFFFF_FFFF); rdv(8'h14, 32'hFFFF_F000, "R2");
    wr(8'h24, 3'd4, 32'hFFFF_FFFF); rdv(8'h24, 32'hFFFF_FF80, "R1");
    wr(8'h18, 3'd4, 32'hFFFF_FFFF); rdv(8'h18, 32'h0000_000C, "R3");
    wr(8'h1C, 3'd4, 32'hFFFF_FFFF); rdv(8'h1C, 32'hFFFF_FFFE, "R4");
    wr(8'h20, 3'd4, 32'hFFFF_FFFF); rdv(8'h20, 32'h0, "R5");

    wr(8'h14, 3'd2, 32'h0000_1234); rdv(8'h14, 32'hFFFF_F000, "R5");
    wr(8'h15, 3'd4, 32'h0000_0000); rdv(8'h14, 32'hFFFF_F000, "R5");
    wr(8'h16, 3'd1, 32'h0000_0000); rdv(8'h14, 32'hFFFF_F000, "R5");

    wr(8'h10, 3'd4, 32'h0000_1003); rdv(8'h10, 32'h0000_1001, "R2");
    wr(8'h14, 3'd4, 32'h8000_0000);
    wr(8'h18, 3'd4, 32'h0);
    wr(8'h1C, 3'd4, 32'h3); rdv(8'h1C, 32'h2, "R4");
    wr(8'h24, 3'd4, 32'h8000_0000);

    wr(8'h04, 3'd1, 32'h1); rdv(8'h04, 32'h1, "R6");
    tx(1'b1, 64'h1004, 4'd4, "R8");
    check(hit && hit_bar == 0 && hit_offset == 4, "R8", hit_offset, 64'h4);
    tx(1'b0, 64'h8000_0010, 4'd4, "R7");
    check(!hit, "R7", {63'h0, hit}, 64'h0);

    @(negedge clk);
    cfg_wr = 1; cfg_addr = 8'h04; cfg_bytes = 3'd4; cfg_wdata = 32'h3;
    txn_valid = 1; txn_io = 0; txn_addr = 64'h8000_0010; txn_len = 4;
    #2 check(!hit, "R6", {63'h0, hit}, 64'h0);
    @(posedge clk); model_write(8'h04, 3'd4, 32'h3);
    #2 check(hit && hit_bar == 1 && hit_offset == 64'h10, "R6", {63'h0, hit}, 64'h1);
    @(negedge clk); cfg_wr = 0;

    tx(1'b0, 64'h8000_0010, 4'd4, "R9");
    check(hit_bar == 1, "R9", 64'(hit_bar), 64'h1);
    tx(1'b0, 64'h8000_0FFC, 4'd4, "R8");
    tx(1'b0, 64'h8000_0FFC, 4'd8, "R8");
    check(!hit, "R8", {63'h0, hit}, 64'h0);
    tx(1'b0, 64'h7FFF_FFFF, 4'd2, "R8");
    tx(1'b0, 64'h2_0000_0100, 4'd8, "R8");
    tx(1'b0, 64'h3_FFFF_FFFC, 4'd4, "R8");
    check(hit_offset == 64'h1_FFFF_FFFC, "R8", hit_offset, 64'h1_FFFF_FFFC);
    tx(1'b0, 64'h4_0000_0000, 4'd1, "R8");
    tx(1'b1, 64'h101F, 4'd2, "R8");

    wr(8'h04, 3'd2, 32'h0);
    tx(1'b1, 64'h1004, 4'd4, "R7");
    check(!hit, "R7", {63'h0, hit}, 64'h0);
    wr(8'h04, 3'd4, 32'h2);
    tx(1'b1, 64'h1004, 4'd4, "R7");
    tx(1'b0, 64'h8000_0004, 4'd4, "R7");

    void'($urandom(32'd1234));
    for (int it = 0; it < 600; it++) begin
      int sel;
      sel = $urandom % 4;
      if (sel == 0) wr(8'h04, 3'($urandom % 2 == 0 ? 3 : 1 + $urandom % 2), $urandom);
      else if (sel == 1) wr(8'h10 + 8'($urandom % 24), ($urandom % 2) ? 3'd4 : 3'd2, $urandom);
      else if (sel == 2) wr(8'h10 + 8'(4 * ($urandom % 6)), 3'd4, $urandom);
      for (int t = 0; t < 3; t++) begin
        int j;
        logic [63:0] base, span, a;
        j = $urandom % 6;
        base = (j == 2) ? {m[3], m[2]} : {32'h0, m[j]};
        span = bsize(j) + 64'd16;
        a = base + ({32'($urandom), 32'($urandom)} % span) - 64'd8;
        tx((j == 0) ? ($urandom % 4 != 0) : ($urandom % 4 == 0), a, 4'(1 + $urandom % 8), "R8");
      end
      rd(8'(4 * ($urandom % 12)), "R2");
    end

    @(negedge clk); txn_valid = 0;
    #2 check(!hit && hit_offset == 0, "R10", {63'h0, hit}, 64'h0);
    finish_run();
  end
endmodule